// File: doc/BRIEF.md
# Zero-Aware Diminished-One Modulo 2^n+1 Adder

This block adds two residues modulo 2^n+1 held in diminished-one form: each operand is an n-bit number part carrying the value minus one, together with a flag that marks the value zero. When neither flag is set, a sparse parallel-prefix adder forms the sum. It computes group carries only at 4-bit block boundaries, and 4-bit blocks ripple the sum bits out of those carries. The inverted carry-out is fed back as the carry-in inside the same prefix levels. A suffix tree supplies the upper-group generate for every boundary, so no increment stage follows the adder.

The zero flags are reduced to an OR and an AND term. These terms steer an output multiplexer that passes the other operand, forces zero, or selects the adder. A third zero case arises when both operands are non-zero and their true sum is a multiple of 2^n+1. The adder detects this case from the all-propagate term and raises the result-zero flag. An optional output register, present by default, adds one cycle of latency.

Top module: `dm1_modadd`

## Requirements
- R1: With both zero flags clear and a_num + b_num >= 2^n, s_num equals (a_num + b_num) mod 2^n and s_zero is 0.
- R2: With both zero flags clear and a_num + b_num < 2^n - 1, s_num equals a_num + b_num + 1 and s_zero is 0.
- R3: With both zero flags clear and a_num + b_num = 2^n - 1, s_zero is 1 and s_num is 0.
- R4: With a_zero = 1 and b_zero = 0, s_num equals b_num and s_zero is 0.
- R5: With b_zero = 1 and a_zero = 0, s_num equals a_num and s_zero is 0.
- R6: With both zero flags set, s_zero is 1 and s_num is 0.
- R7: The number part of an operand whose zero flag is 1 has no effect on the outputs.
- R8: With REG_OUT = 1, outputs change only on the rising clock edge after the inputs, and an active-low reset drives s_num to 0 and s_zero to 1.
- R9: Whenever s_zero is 1, s_num is 0.
- R10: Decoding each side as (flag ? 0 : number + 1), the output equals (A + B) mod (2^n + 1) for every operand pair, including zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_num | input | N | Number part of operand A (value minus one) |
| a_zero | input | 1 | High when operand A is zero |
| b_num | input | N | Number part of operand B (value minus one) |
| b_zero | input | 1 | High when operand B is zero |
| s_num | output | N | Number part of the sum (value minus one) |
| s_zero | output | 1 | High when the sum is zero |

## Verification
A wrong block carry, most often a mishandled end-around term, shows up as a result that is off by one in a single 4-bit group. It appears on the ports in the cycle after the operands are applied, because the only state is the output register. A fault in the flag multiplexer shows as the wrong operand passed through, or as a zero flag that disagrees with the number part. The exhaustive 4-bit sweep exposes either kind of fault on the first pair that hits it. The 16-bit table targets multi-block carry chains and the wrap-to-zero boundary.

// File: rtl/dm1_pkg.sv
`timescale 1ns/1ps
package dm1_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    localparam gp_t GP_IDENT = '{g: 1'b0, p: 1'b1};

    // hi is the more significant span, lo the less significant one
    function automatic gp_t gp_combine(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/dm1_blk_pg.sv
`timescale 1ns/1ps
module dm1_blk_pg #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output dm1_pkg::gp_t   grp
);
    import dm1_pkg::*;

    always_comb begin
        gp_t acc;
        gp_t bitgp;
        acc = GP_IDENT;
        for (int i = 0; i < W; i++) begin
            bitgp.g = a[i] & b[i];
            bitgp.p = a[i] ^ b[i];
            acc = gp_combine(bitgp, acc);
        end
        grp = acc;
    end
endmodule

// File: rtl/dm1_blk_sum.sv
`timescale 1ns/1ps
module dm1_blk_sum #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum
);
    always_comb begin
        logic c;
        c = cin;
        for (int i = 0; i < W; i++) begin
            sum[i] = a[i] ^ b[i] ^ c;
            c = (a[i] & b[i]) | ((a[i] ^ b[i]) & c);
        end
    end
endmodule

// File: rtl/dm1_prefix_tree.sv
`timescale 1ns/1ps
module dm1_prefix_tree #(
    parameter int COUNT   = 4,
    parameter bit REVERSE = 1'b0
) (
    input  dm1_pkg::gp_t [COUNT-1:0] leaf,
    output dm1_pkg::gp_t [COUNT-1:0] span
);
    import dm1_pkg::*;

    localparam int LEVELS = (COUNT > 1) ? $clog2(COUNT) : 0;

    gp_t [COUNT-1:0] stage [LEVELS+1];

    assign stage[0] = leaf;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
        localparam int D = 1 << lv;
        for (genvar k = 0; k < COUNT; k++) begin : g_node
            if (k >= D) begin : g_op
                if (REVERSE) begin : g_rev
                    // lower index of the reversed order is more significant
                    assign stage[lv+1][k] = gp_combine(stage[lv][k-D], stage[lv][k]);
                end else begin : g_fwd
                    assign stage[lv+1][k] = gp_combine(stage[lv][k], stage[lv][k-D]);
                end
            end else begin : g_pass
                assign stage[lv+1][k] = stage[lv][k];
            end
        end
    end

    assign span = stage[LEVELS];
endmodule

// File: rtl/dm1_modadd.sv
`timescale 1ns/1ps
module dm1_modadd #(
    parameter int N       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] a_num,
    input  logic         a_zero,
    input  logic [N-1:0] b_num,
    input  logic         b_zero,
    output logic [N-1:0] s_num,
    output logic         s_zero
);
    import dm1_pkg::*;

    localparam int BLK = 4;
    localparam int NB  = N / BLK;

    typedef struct packed {
        logic         zero;
        logic [N-1:0] num;
    } res_t;

    localparam res_t RES_RESET = '{zero: 1'b1, num: '0};

    gp_t [NB-1:0] blk_gp;
    gp_t [NB-1:0] rev_leaf;
    gp_t [NB-1:0] pre_span;
    gp_t [NB-1:0] rev_span;
    logic [NB-1:0] blk_cin;
    logic [N-1:0]  sum_raw;
    logic          g_all;
    logic          p_all;
    res_t          res_d;
    res_t          res_q;

    // block generate / propagate and the reversed copy for the suffix tree
    for (genvar k = 0; k < NB; k++) begin : g_blk
        dm1_blk_pg #(.W(BLK)) u_pg (
            .a   (a_num[k*BLK +: BLK]),
            .b   (b_num[k*BLK +: BLK]),
            .grp (blk_gp[k])
        );
        assign rev_leaf[k] = blk_gp[NB-1-k];
    end

    dm1_prefix_tree #(.COUNT(NB), .REVERSE(1'b0)) u_low (
        .leaf (blk_gp),
        .span (pre_span)
    );

    dm1_prefix_tree #(.COUNT(NB), .REVERSE(1'b1)) u_high (
        .leaf (rev_leaf),
        .span (rev_span)
    );

    assign g_all = pre_span[NB-1].g;
    assign p_all = pre_span[NB-1].p;

    // carry into block k: G[low] | P[low] & ~G[high], high spanning blocks k..NB-1
    for (genvar k = 0; k < NB; k++) begin : g_cin
        gp_t low_k;
        if (k == 0) begin : g_first
            assign low_k = GP_IDENT;
        end else begin : g_rest
            assign low_k = pre_span[k-1];
        end
        assign blk_cin[k] = low_k.g | (low_k.p & ~rev_span[NB-1-k].g);

        dm1_blk_sum #(.W(BLK)) u_sum (
            .a   (a_num[k*BLK +: BLK]),
            .b   (b_num[k*BLK +: BLK]),
            .cin (blk_cin[k]),
            .sum (sum_raw[k*BLK +: BLK])
        );
    end

    // flag-steered output selection
    always_comb begin
        logic any_zero;
        logic both_zero;
        any_zero  = a_zero | b_zero;
        both_zero = a_zero & b_zero;
        res_d     = RES_RESET;
        if (both_zero) begin
            res_d = RES_RESET;
        end else if (any_zero) begin
            res_d.zero = 1'b0;
            res_d.num  = a_zero ? b_num : a_num;
        end else begin
            res_d.zero = p_all;
            res_d.num  = sum_raw;
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= RES_RESET;
            else        res_q <= res_d;
        end

        AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
            s_zero |-> (s_num == '0)); // R9

        AST_BOTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(a_zero && b_zero)) |-> (s_zero && s_num == '0)); // R6

        AST_PASS_A: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(b_zero && !a_zero)) |-> (!s_zero && s_num == $past(a_num))); // R5

        AST_PASS_B: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(a_zero && !b_zero)) |-> (!s_zero && s_num == $past(b_num))); // R4
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign s_num  = res_q.num;
    assign s_zero = res_q.zero;

    // adder core checks against a plain binary sum
    always_comb begin
        logic [N:0] ref_sum;
        ref_sum = {1'b0, a_num} + {1'b0, b_num};
        if (!a_zero && !b_zero && g_all) begin
            AST_CARRY_PATH: assert (sum_raw == ref_sum[N-1:0]); // R1
        end
        if (!a_zero && !b_zero && !g_all && !p_all) begin
            AST_NOCARRY_PATH: assert (sum_raw == N'(ref_sum + 1'b1)); // R2
        end
        if (!a_zero && !b_zero && p_all) begin
            AST_WRAP_ZERO: assert (sum_raw == '0 && !g_all); // R3
        end
    end
endmodule

// File: tb/dm1_modadd_test.sv
`timescale 1ns/1ps
module dm1_modadd_test;

    localparam int NW = 16;
    localparam int NS = 4;

    typedef struct packed {
        logic          az;
        logic [NW-1:0] a;
        logic          bz;
        logic [NW-1:0] b;
        logic          ez;
        logic [NW-1:0] en;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0003, 1'b0, 16'h0004, 1'b0, 16'h0008},  // R2
        '{1'b0, 16'hFFFF, 1'b0, 16'h0002, 1'b0, 16'h0001},  // R1
        '{1'b0, 16'h1234, 1'b0, 16'hEDCB, 1'b1, 16'h0000},  // R3
        '{1'b1, 16'hABCD, 1'b0, 16'h0042, 1'b0, 16'h0042},  // R4 R7
        '{1'b0, 16'h0777, 1'b1, 16'h5555, 1'b0, 16'h0777},  // R5 R7
        '{1'b1, 16'h1357, 1'b1, 16'h2468, 1'b1, 16'h0000},  // R6
        '{1'b0, 16'h8000, 1'b0, 16'h8000, 1'b0, 16'h0000},  // R1
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0001},  // R2
        '{1'b0, 16'hFFFF, 1'b0, 16'hFFFF, 1'b0, 16'hFFFE},  // R1
        '{1'b0, 16'h0FFF, 1'b0, 16'h0000, 1'b0, 16'h1000},  // R2
        '{1'b0, 16'h00FF, 1'b0, 16'hFF00, 1'b1, 16'h0000}   // R3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NW-1:0] a_num = '0, b_num = '0, s_num;
    logic a_zero = 1'b0, b_zero = 1'b0, s_zero;
    logic [NS-1:0] a4 = '0, b4 = '0, s4;
    logic a4z = 1'b0, b4z = 1'b0, s4z;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dm1_modadd #(.N(NW), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_num(a_num), .a_zero(a_zero), .b_num(b_num), .b_zero(b_zero),
        .s_num(s_num), .s_zero(s_zero)
    );

    dm1_modadd #(.N(NS), .REG_OUT(1'b1)) uut4 (
        .clk(clk), .rst_n(rst_n),
        .a_num(a4), .a_zero(a4z), .b_num(b4), .b_zero(b4z),
        .s_num(s4), .s_zero(s4z)
    );

    task automatic chk(input string req, input logic act_z, input logic [NW-1:0] act_n,
                       input logic exp_z, input logic [NW-1:0] exp_n);
        checks++;
        if (act_z !== exp_z || act_n !== exp_n) begin
            errors++;
            $display("FAIL %s: got zero=%0b num=%h, expected zero=%0b num=%h",
                     req, act_z, act_n, exp_z, exp_n);
        end
    endtask

    // modular reference: decode, add, reduce, re-encode
    function automatic void model(input int n, input logic az, input longint a,
                                  input logic bz, input longint b,
                                  output logic ez, output logic [NW-1:0] en);
        longint m, va, vb, s;
        m  = (longint'(1) << n) + 1;
        va = az ? 0 : a + 1;
        vb = bz ? 0 : b + 1;
        s  = (va + vb) % m;
        ez = (s == 0);
        en = (s == 0) ? '0 : NW'(s - 1);
    endfunction

    function automatic string tag_of(input vec_t v);
        if (v.az && v.bz) return "R6";
        if (v.az)         return "R4";
        if (v.bz)         return "R5";
        if (v.ez)         return "R3";
        if ({1'b0, v.a} + {1'b0, v.b} >= 17'h10000) return "R1";
        return "R2";
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running, expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ez;
        logic [NW-1:0] en;

        // reset state, R8
        repeat (3) @(negedge clk);
        chk("R8 reset", s_zero, s_num, 1'b1, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            a_zero = VECS[i].az; a_num = VECS[i].a;
            b_zero = VECS[i].bz; b_num = VECS[i].b;
            @(negedge clk);
            chk(tag_of(VECS[i]), s_zero, s_num, VECS[i].ez, VECS[i].en);
        end

        // R7: altering the number part of a zero operand leaves the output unchanged
        a_zero = 1'b1; a_num = 16'h1111; b_zero = 1'b0; b_num = 16'h0042;
        @(negedge clk);
        chk("R7 a ignored", s_zero, s_num, 1'b0, 16'h0042);
        a_zero = 1'b0; a_num = 16'h0777; b_zero = 1'b1; b_num = 16'hFFFF;
        @(negedge clk);
        chk("R7 b ignored", s_zero, s_num, 1'b0, 16'h0777);

        // R8: new inputs do not reach the outputs before the clock edge
        a_zero = 1'b0; a_num = 16'h0010; b_zero = 1'b0; b_num = 16'h0020;
        #1;
        chk("R8 hold", s_zero, s_num, 1'b0, 16'h0777);
        @(negedge clk);
        chk("R8 update", s_zero, s_num, 1'b0, 16'h0031);

        // R10 random 16-bit operands
        for (int i = 0; i < 300; i++) begin
            a_zero = ($urandom % 8) == 0; a_num = NW'($urandom);
            b_zero = ($urandom % 8) == 0; b_num = NW'($urandom);
            if (i % 10 == 0) b_num = ~a_num;
            @(negedge clk);
            model(NW, a_zero, longint'(a_num), b_zero, longint'(b_num), ez, en);
            chk("R10 n16", s_zero, s_num, ez, en);
        end

        // R10 exhaustive 4-bit sweep
        for (int az = 0; az < 2; az++)
            for (int av = 0; av < 16; av++)
                for (int bz = 0; bz < 2; bz++)
                    for (int bv = 0; bv < 16; bv++) begin
                        a4z = az[0]; a4 = NS'(av); b4z = bz[0]; b4 = NS'(bv);
                        @(negedge clk);
                        model(NS, az[0], longint'(av), bz[0], longint'(bv), ez, en);
                        chk("R10 n4", s4z, {12'h000, s4}, ez, en);
                    end

        // R8: asynchronous reset mid-run
        a_zero = 1'b0; a_num = 16'h0100; b_zero = 1'b0; b_num = 16'h0200;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R8 async reset", s_zero, s_num, 1'b1, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 after reset", s_zero, s_num, 1'b0, 16'h0301);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule